// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block guesses whether a conditional branch will be taken. It holds a table of small saturating state entries. The low-order bits of the program counter, above the byte offset of a word-aligned instruction, select the entry. The fetch stage presents its PC on the lookup port and gets back a taken/not-taken guess in the same cycle, with no clock edge in between.

When the pipeline resolves a branch, it presents the branch PC and the actual outcome on the update port. The block reads the selected entry and passes it through a single next-state function that all entries share. It writes the result back at the next clock edge. A parameter turns each entry into a single bit that remembers the last outcome. With this hysteresis removed, a loop branch costs two mispredictions per visit instead of one.

After reset the block walks through the table and sets every entry to its initial state. While it does this, a busy output is high, predictions read as not-taken and updates are dropped.

Top module: `bpred_table`

## Requirements
- R1: The entry index is PC bits [log2(DEPTH)+1:2]. Two PCs that differ only in bits 1:0 or in bits above the index select the same entry, and no tag check is made.
- R2: In two-bit mode an entry is coded 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The prediction is the upper bit. Every entry starts at 01 after the reset sweep.
- R3: A taken update in two-bit mode moves the entry 00→01, 01→10, 10→11 and 11→11.
- R4: A not-taken update in two-bit mode moves the entry 11→10, 10→01, 01→00 and 00→00.
- R5: With ONE_BIT_MODE set, an entry is one bit. It starts at 0 (not-taken), an update stores the outcome (1 taken), and the prediction equals that bit.
- R6: pred_taken follows lookup_pc in the same cycle. When an update hits the looked-up entry in that same cycle, the prediction shows the value before the update, and the new value appears after the next rising clock edge.
- R7: While rst_n is low, busy is 1 and pred_taken is 0. After rst_n rises, busy stays 1 for exactly DEPTH rising edges, then falls and stays low until the next reset.
- R8: An update has no effect on the table while busy is 1 or while upd_valid is 0.
- R9: For a loop branch taken four times and then not taken, repeated over visits, two-bit mode mispredicts once per visit after the first and one-bit mode mispredicts twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the clearing sweep |
| lookup_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | 1 = predicted taken |
| busy | output | 1 | 1 while the table is being cleared |
| upd_valid | input | 1 | 1 = a resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Because the lookup path has no register, a prediction is due in the same cycle as its PC. An update is due only after the rising edge that follows the cycle in which it was presented. The bench therefore drives inputs on falling edges, applies each update for one rising edge, and reads the prediction 1 ns after the next falling edge. For the same-cycle collision case it also reads once before that rising edge, to see the pre-update value. Busy is due to fall on the DEPTH-th rising edge after reset release, so the bench counts falling edges until busy drops and compares the count with DEPTH.

// File: rtl/bpred_table.sv
module bpred_table #(
  parameter int DEPTH        = 4096,
  parameter bit ONE_BIT_MODE = 1'b0,
  parameter int PC_W         = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            pred_taken,
  output logic            busy,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ENT_W = ONE_BIT_MODE ? 1 : 2;
  localparam logic [ENT_W-1:0] INIT_ENT = ONE_BIT_MODE ? '0 : ENT_W'(1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [IDX_W-1:0] clr_idx;
  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [ENT_W-1:0] lk_ent, up_ent, nxt_ent;

  assign lk_idx = lookup_pc[IDX_W+1:2];
  assign up_idx = upd_pc[IDX_W+1:2];
  assign lk_ent = ent_q[lk_idx];
  assign up_ent = ent_q[up_idx];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc[1:0], upd_pc[1:0],
                            lookup_pc[PC_W-1:IDX_W+2], upd_pc[PC_W-1:IDX_W+2]};

  generate
    if (ONE_BIT_MODE) begin : g_last
      assign nxt_ent = upd_taken;
    end else begin : g_sat
      always_comb begin
        if (upd_taken) nxt_ent = (&up_ent) ? up_ent : up_ent + 2'd1;
        else           nxt_ent = (~|up_ent) ? up_ent : up_ent - 2'd1;
      end
    end
  endgenerate

  assign pred_taken = !busy && lk_ent[ENT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b1;
      clr_idx <= '0;
    end else if (busy) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == LAST_IDX) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy)           ent_q[clr_idx] <= INIT_ENT;
    else if (upd_valid) ent_q[up_idx]  <= nxt_ent;
  end
endmodule

// File: rtl/bpred_table_chk.sv
module bpred_table_chk #(
  parameter int DEPTH        = 4096,
  parameter bit ONE_BIT_MODE = 1'b0,
  parameter int PC_W         = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lookup_pc,
  input logic            pred_taken,
  input logic            busy,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W:0] busy_cnt;
  logic           hit;
  logic           unused_chk_bits;

  assign hit = lookup_pc[IDX_W+1:2] == upd_pc[IDX_W+1:2];
  assign unused_chk_bits = ^{lookup_pc[1:0], upd_pc[1:0],
                             lookup_pc[PC_W-1:IDX_W+2], upd_pc[PC_W-1:IDX_W+2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == (IDX_W+1)'(DEPTH)); // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < (IDX_W+1)'(DEPTH)); // R7
  AST_NO_REBUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !upd_valid) |=> (lookup_pc != $past(lookup_pc) || $stable(pred_taken))); // R8

  generate
    if (ONE_BIT_MODE) begin : g_one
      AST_ONEBIT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_valid && hit) |=>
        (lookup_pc != $past(lookup_pc) || pred_taken == $past(upd_taken))); // R5
    end else begin : g_two
      AST_TAKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_valid && upd_taken && hit && pred_taken) |=>
        (lookup_pc != $past(lookup_pc) || pred_taken)); // R3
      AST_NT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_valid && !upd_taken && hit && !pred_taken) |=>
        (lookup_pc != $past(lookup_pc) || !pred_taken)); // R4
    end
  endgenerate
endmodule

bind bpred_table bpred_table_chk #(
  .DEPTH(DEPTH), .ONE_BIT_MODE(ONE_BIT_MODE), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred_taken),
  .busy(busy), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
);

// File: tb/bpred_table_tb.sv
module bpred_table_tb;
  localparam int DEPTH = 64;
  localparam int PC_W  = 32;
  localparam int NVEC  = 13;
  // {pc[11:0], taken, expected two-bit pred, expected one-bit pred}
  localparam logic [14:0] VEC [NVEC] = '{
    {12'h104, 1'b1, 1'b1, 1'b1}, {12'h104, 1'b1, 1'b1, 1'b1},
    {12'h104, 1'b1, 1'b1, 1'b1}, {12'h104, 1'b0, 1'b1, 1'b0},
    {12'h104, 1'b1, 1'b1, 1'b1}, {12'h104, 1'b0, 1'b1, 1'b0},
    {12'h104, 1'b0, 1'b0, 1'b0}, {12'h104, 1'b0, 1'b0, 1'b0},
    {12'h104, 1'b1, 1'b0, 1'b1}, {12'h208, 1'b0, 1'b0, 1'b0},
    {12'h208, 1'b1, 1'b0, 1'b1}, {12'h208, 1'b1, 1'b1, 1'b1},
    {12'h208, 1'b0, 1'b0, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lookup_pc = '0;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic            pred2, pred1, busy2, busy1;
  int              n_cmp = 0;
  int              n_bad = 0;

  always #10 clk = ~clk;

  bpred_table #(.DEPTH(DEPTH), .ONE_BIT_MODE(1'b0), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred2), .busy(busy2),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  bpred_table #(.DEPTH(DEPTH), .ONE_BIT_MODE(1'b1), .PC_W(PC_W)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred1), .busy(busy1),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_upd(input logic [PC_W-1:0] pc, input logic t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(input logic [PC_W-1:0] pc);
    lookup_pc = pc;
    #1;
  endtask

  // reset, with a taken update held on idx 5 during the whole sweep (R8)
  task automatic do_reset(input logic [PC_W-1:0] look_pc);
    int cnt;
    @(negedge clk);
    rst_n = 1'b0;
    look(look_pc);
    chk("R7 busy in reset", busy2, 1'b1);
    chk("R7 pred low in reset", pred2, 1'b0);
    chk("R7 pred low in reset one-bit", pred1, 1'b0);
    repeat (2) @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h514; upd_taken = 1'b1;
    rst_n = 1'b1;
    cnt = 0;
    while (busy2 && cnt < 4 * DEPTH) begin
      @(negedge clk);
      cnt++;
    end
    upd_valid = 1'b0;
    chk_int("R7 busy length", cnt, DEPTH);
    chk("R7 busy both", busy1, 1'b0);
    look(32'h514);
    chk("R8 update during busy ignored", pred2, 1'b0);
    chk("R8 update during busy ignored one-bit", pred1, 1'b0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int mis2, mis1;
    do_reset(32'h0);

    for (int i = 0; i < DEPTH; i++) begin
      look(32'(i * 4));
      chk("R2 initial weak not-taken", pred2, 1'b0);
      chk("R5 initial zero one-bit", pred1, 1'b0);
    end

    for (int i = 0; i < NVEC; i++) begin
      do_upd({20'h0, VEC[i][14:3]}, VEC[i][2]);
      look({20'h0, VEC[i][14:3]});
      chk(VEC[i][2] ? "R3 taken transition" : "R4 not-taken transition", pred2, VEC[i][1]);
      chk("R5 one-bit follows outcome", pred1, VEC[i][0]);
    end

    mis2 = 0; mis1 = 0;
    for (int v = 0; v < 2; v++) begin
      for (int i = 0; i < 5; i++) begin
        look(32'h30C);
        if (v == 1 && pred2 != (i < 4)) mis2++;
        if (v == 1 && pred1 != (i < 4)) mis1++;
        do_upd(32'h30C, i < 4);
      end
    end
    chk_int("R9 loop mispredicts two-bit", mis2, 1);
    chk_int("R9 loop mispredicts one-bit", mis1, 2);

    @(negedge clk);
    lookup_pc = 32'h410; upd_pc = 32'h410; upd_taken = 1'b1; upd_valid = 1'b1;
    #1;
    chk("R6 pre-update value on collision", pred2, 1'b0);
    chk("R6 pre-update value on collision one-bit", pred1, 1'b0);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk("R6 new value after edge", pred2, 1'b1);
    chk("R6 new value after edge one-bit", pred1, 1'b1);
    look(32'h510);
    chk("R1 alias above index", pred2, 1'b1);
    look(32'h413);
    chk("R1 alias in low bits", pred2, 1'b1);
    look(32'h414);
    chk("R1 neighbour entry separate", pred2, 1'b0);

    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h618; upd_taken = 1'b1;
    repeat (3) @(negedge clk);
    look(32'h618);
    chk("R8 invalid update ignored", pred2, 1'b0);
    chk("R8 invalid update ignored one-bit", pred1, 1'b0);

    do_reset(32'h410);
    look(32'h410);
    chk("R7 entry cleared by reset", pred2, 1'b0);
    chk("R7 entry cleared by reset one-bit", pred1, 1'b0);
    do_upd(32'h410, 1'b1);
    look(32'h410);
    chk("R2 weak not-taken to taken in one step", pred2, 1'b1);

    finish_run();
  end
endmodule